// File: doc/BRIEF.md
# Masked bus match comparator

This block watches a processor bus every cycle. It raises a one-cycle match pulse when the observed access agrees with the compare values that software has programmed. The address is always compared, as a full 24-bit equality. When the data option is built in and switched on, the 16-bit data bus is compared as well. Each data bit has its own mask bit, so a chosen set of bits can be left out of the comparison. Two optional qualifiers can narrow the match further: one on the access direction (read or write), and one on the access size (byte or word). When the size qualifier asks for byte accesses, only the data byte lane picked by address bit 0 takes part in the data comparison.

Compare values and control bits are loaded one byte at a time through a small register-write port. A build-time parameter, `HAS_DATA`, selects between two variants. The full comparator has the data and mask registers and the masked data path. The address-only comparator has neither, and its data-enable control bit has no effect. A debug controller would place several instances side by side and feed their match pulses to a sequencer.

Top module: `bus_match_cmp`

## Requirements
- R1: After reset, `match` is low and every compare register (address, data, mask and control) holds zero. The comparator is therefore disabled, and once it is enabled it matches address 0.
- R2: A write with `wr_en` high stores `wr_data` into the register chosen by `wr_sel`: 0 address bits 7:0, 1 address bits 15:8, 2 address bits 23:16, 3 data bits 7:0, 4 data bits 15:8, 5 mask bits 7:0, 6 mask bits 15:8, 7 control. The control bits are: bit0 enable, bit1 data compare enable, bit2 direction qualifier enable, bit3 required direction (1 = read), bit4 size qualifier enable, bit5 required size (1 = byte).
- R3: `match` can be high only when the sampled `bus_addr` equals the programmed 24-bit address in every bit.
- R4: A cycle with `bus_valid` low never produces a match.
- R5: While the enable bit is clear, `match` stays low whatever the bus shows.
- R6: With data compare on and no byte qualification, a match needs `bus_data` to equal the programmed data in every bit whose mask bit is 1. Bits whose mask bit is 0 are ignored.
- R7: With the direction qualifier on, a match needs `bus_rw` (1 = read) to equal the programmed direction bit.
- R8: With the size qualifier on, a match needs `bus_byte` (1 = byte access) to equal the programmed size bit.
- R9: With data compare on and the size qualifier requiring byte accesses, only one lane is compared. Address bit 0 = 0 selects `bus_data[15:8]` and address bit 0 = 1 selects `bus_data[7:0]`. The other lane is ignored.
- R10: In the address-only variant (`HAS_DATA` = 0), the data enable bit and the data bus have no effect on `match`.
- R11: `match` is registered. It goes high in the cycle after a qualifying bus cycle and lasts one cycle for each qualifying cycle, so back-to-back hits give back-to-back pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register index for the write |
| wr_data | input | 8 | Byte to write |
| bus_valid | input | 1 | Bus cycle valid strobe |
| bus_addr | input | 24 | Observed address |
| bus_data | input | 16 | Observed data |
| bus_rw | input | 1 | Observed direction, 1 = read |
| bus_byte | input | 1 | Observed size, 1 = byte access |
| match | output | 1 | Registered one-cycle match pulse |

## Verification
The bench probes the address compare one bit away from the programmed value, in both the low and the high byte. A comparator that dropped an address bit would match there. It flips data bits under a zero mask and under a one mask. A design with the mask inverted, or with the mask ignored, would give the wrong answer on one of the two. Under byte qualification it changes the lane that should be ignored and the lane that should be compared, at both values of address bit 0. Swapped lanes would match the wrong byte. The bench also checks that an address-only instance ignores a data mismatch, and that back-to-back hits give two pulses instead of one stretched or lost pulse.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

   localparam int REG_W  = 8;
   localparam int CTRL_W = 6;

   // Control register layout, LSB first: enable, data_en, rw_en, rw_val, size_en, size_val
   typedef struct packed {
      logic size_val;   // 1 = byte access required
      logic size_en;
      logic rw_val;     // 1 = read required
      logic rw_en;
      logic data_en;
      logic enable;
   } bmc_ctrl_t;

endpackage

// File: rtl/bmc_regs.sv
module bmc_regs
   import bmc_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int DATA_W   = 16,
   parameter bit HAS_DATA = 1'b1,
   localparam int AB      = ADDR_W / REG_W,
   localparam int DB      = DATA_W / REG_W,
   localparam int NREG    = AB + 2 * DB + 1,
   localparam int SEL_W   = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [REG_W-1:0]  wr_data,
   output logic [ADDR_W-1:0] cmp_addr,
   output logic [DATA_W-1:0] cmp_data,
   output logic [DATA_W-1:0] cmp_mask,
   output bmc_ctrl_t         ctrl
);

   localparam int DATA_BASE = AB;
   localparam int MASK_BASE = AB + DB;
   localparam int CTRL_IDX  = AB + 2 * DB;

   logic [ADDR_W-1:0] addr_q;
   bmc_ctrl_t         ctrl_q;
   logic              unused_wr_hi;

   assign unused_wr_hi = ^wr_data[REG_W-1:CTRL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < AB; i++) begin
            if (wr_sel == SEL_W'(i)) addr_q[REG_W*i +: REG_W] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en && wr_sel == SEL_W'(CTRL_IDX)) begin
         ctrl_q <= bmc_ctrl_t'(wr_data[CTRL_W-1:0]);
      end
   end

   assign cmp_addr = addr_q;

   generate
      if (HAS_DATA) begin : g_data_regs
         logic [DATA_W-1:0] data_q;
         logic [DATA_W-1:0] mask_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_q <= '0;
               mask_q <= '0;
            end else if (wr_en) begin
               for (int j = 0; j < DB; j++) begin
                  if (wr_sel == SEL_W'(DATA_BASE + j)) data_q[REG_W*j +: REG_W] <= wr_data;
                  if (wr_sel == SEL_W'(MASK_BASE + j)) mask_q[REG_W*j +: REG_W] <= wr_data;
               end
            end
         end

         assign cmp_data = data_q;
         assign cmp_mask = mask_q;

         always_comb begin
            ctrl = ctrl_q;
         end
      end else begin : g_no_data_regs
         assign cmp_data = '0;
         assign cmp_mask = '0;

         always_comb begin
            ctrl         = ctrl_q;
            ctrl.data_en = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/bmc_bus_qual.sv
module bmc_bus_qual
   import bmc_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [ADDR_W-1:0] cmp_addr,
   input  logic              bus_rw,
   input  logic              bus_byte,
   input  bmc_ctrl_t         ctrl,
   output logic              addr_eq,
   output logic              qual_ok
);

   logic rw_ok;
   logic size_ok;

   assign addr_eq = (bus_addr == cmp_addr);
   assign rw_ok   = !ctrl.rw_en   || (bus_rw   == ctrl.rw_val);
   assign size_ok = !ctrl.size_en || (bus_byte == ctrl.size_val);
   assign qual_ok = rw_ok && size_ok;

endmodule

// File: rtl/bmc_data_cmp.sv
module bmc_data_cmp
   import bmc_pkg::*;
#(
   parameter int DATA_W = 16,
   localparam int LANES = DATA_W / REG_W,
   localparam int LSB_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [DATA_W-1:0] bus_data,
   input  logic [LSB_W-1:0]  bus_lsb,
   input  logic [DATA_W-1:0] cmp_data,
   input  logic [DATA_W-1:0] cmp_mask,
   input  logic              byte_mode,
   output logic              data_eq
);

   logic [LANES-1:0] lane_ok;

   // Big-endian lane order: lowest address picks the most significant lane
   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         logic             lane_on;
         logic [REG_W-1:0] diff;

         assign lane_on    = !byte_mode || (bus_lsb == LSB_W'(LANES - 1 - k));
         assign diff       = (bus_data[REG_W*k +: REG_W] ^ cmp_data[REG_W*k +: REG_W])
                             & cmp_mask[REG_W*k +: REG_W];
         assign lane_ok[k] = !lane_on || (diff == '0);
      end
   endgenerate

   assign data_eq = &lane_ok;

endmodule

// File: rtl/bus_match_cmp.sv
module bus_match_cmp
   import bmc_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int DATA_W   = 16,
   parameter bit HAS_DATA = 1'b1,
   localparam int SEL_W   = $clog2(ADDR_W / 8 + 2 * (DATA_W / 8) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [7:0]        wr_data,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              bus_rw,
   input  logic              bus_byte,
   output logic              match
);

   localparam int LANES = DATA_W / REG_W;
   localparam int LSB_W = (LANES > 1) ? $clog2(LANES) : 1;

   generate
      if (ADDR_W % REG_W != 0 || ADDR_W < REG_W) begin : g_bad_addr_w
         $error("ADDR_W must be a non-zero multiple of 8");
      end
      if (DATA_W % REG_W != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_data_w
         $error("DATA_W must be 8 times a power of two, at least 16");
      end
      if (ADDR_W < LSB_W) begin : g_bad_lsb
         $error("ADDR_W too narrow for lane select");
      end
   endgenerate

   logic [ADDR_W-1:0] cmp_addr;
   logic [DATA_W-1:0] cmp_data;
   logic [DATA_W-1:0] cmp_mask;
   bmc_ctrl_t         ctrl;
   logic              addr_eq;
   logic              qual_ok;
   logic              data_ok;
   logic              hit;
   logic              match_q;

   bmc_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .HAS_DATA (HAS_DATA)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .cmp_addr (cmp_addr),
      .cmp_data (cmp_data),
      .cmp_mask (cmp_mask),
      .ctrl     (ctrl)
   );

   bmc_bus_qual #(
      .ADDR_W (ADDR_W)
   ) u_qual (
      .bus_addr (bus_addr),
      .cmp_addr (cmp_addr),
      .bus_rw   (bus_rw),
      .bus_byte (bus_byte),
      .ctrl     (ctrl),
      .addr_eq  (addr_eq),
      .qual_ok  (qual_ok)
   );

   generate
      if (HAS_DATA) begin : g_data
         logic data_eq;

         bmc_data_cmp #(
            .DATA_W (DATA_W)
         ) u_data (
            .bus_data  (bus_data),
            .bus_lsb   (bus_addr[LSB_W-1:0]),
            .cmp_data  (cmp_data),
            .cmp_mask  (cmp_mask),
            .byte_mode (ctrl.size_en && ctrl.size_val),
            .data_eq   (data_eq)
         );

         assign data_ok = !ctrl.data_en || data_eq;

         // R6: word-mode data hits agree with the programmed data on unmasked bits
         assert_masked_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (match && $past(ctrl.data_en) && !($past(ctrl.size_en) && $past(ctrl.size_val)))
            |-> ((($past(bus_data) ^ $past(cmp_data)) & $past(cmp_mask)) == '0));
      end else begin : g_no_data
         logic unused_nodata;
         assign unused_nodata = ^{bus_data, cmp_data, cmp_mask, ctrl.data_en};
         assign data_ok       = 1'b1;
      end
   endgenerate

   assign hit = bus_valid && ctrl.enable && addr_eq && qual_ok && data_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q <= 1'b0;
      else        match_q <= hit;
   end

   assign match = match_q;

   // R4: an idle bus cycle never yields a pulse
   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> !match);

   // R5: pulse only while the comparator was enabled
   assert_enable_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      match |-> $past(ctrl.enable));

   // R3: pulse only for an exact address
   assert_addr_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      match |-> ($past(bus_addr) == $past(cmp_addr)));

   // R7: direction qualifier respected
   assert_rw_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (match && $past(ctrl.rw_en)) |-> ($past(bus_rw) == $past(ctrl.rw_val)));

   // R8: size qualifier respected
   assert_size_qual_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (match && $past(ctrl.size_en)) |-> ($past(bus_byte) == $past(ctrl.size_val)));

endmodule

// File: tb/bus_match_cmp_bench.sv
module bus_match_cmp_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [7:0]  wr_data = '0;
   logic        bus_valid = 1'b0;
   logic [23:0] bus_addr = '0;
   logic [15:0] bus_data = '0;
   logic        bus_rw = 1'b0;
   logic        bus_byte = 1'b0;
   logic        match;
   logic        match_nd;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   // requirement-level model state
   logic [23:0] m_addr = '0;
   logic [15:0] m_data = '0;
   logic [15:0] m_mask = '0;
   logic [5:0]  m_ctrl = '0;

   typedef struct {
      int   due;
      logic e;
      logic e_nd;
      int   req;
   } item_t;

   item_t q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   bus_match_cmp u_bus_match_cmp (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
      .bus_valid (bus_valid), .bus_addr (bus_addr), .bus_data (bus_data),
      .bus_rw (bus_rw), .bus_byte (bus_byte), .match (match)
   );

   // R10: address-only variant driven by the same stimulus
   bus_match_cmp #(.HAS_DATA (1'b0)) u_bus_match_cmp_nodata (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
      .bus_valid (bus_valid), .bus_addr (bus_addr), .bus_data (bus_data),
      .bus_rw (bus_rw), .bus_byte (bus_byte), .match (match_nd)
   );

   function automatic logic model(input logic [23:0] a, input logic [15:0] d,
                                  input logic rw, input logic byt, input logic vld,
                                  input logic hasd);
      logic        ok;
      logic [15:0] diff;
      ok = vld && m_ctrl[0] && (a == m_addr);
      if (m_ctrl[2] && rw != m_ctrl[3]) ok = 1'b0;
      if (m_ctrl[4] && byt != m_ctrl[5]) ok = 1'b0;
      if (hasd && m_ctrl[1]) begin
         diff = (d ^ m_data) & m_mask;
         if (m_ctrl[4] && m_ctrl[5]) diff = a[0] ? (diff & 16'h00FF) : (diff & 16'hFF00);
         if (diff != '0) ok = 1'b0;
      end
      return ok;
   endfunction

   task automatic drive(input logic we, input logic [2:0] sel, input logic [7:0] wd,
                        input logic vld, input logic [23:0] a, input logic [15:0] d,
                        input logic rw, input logic byt, input int req);
      item_t it;
      @(negedge clk);
      wr_en = we; wr_sel = sel; wr_data = wd;
      bus_valid = vld; bus_addr = a; bus_data = d; bus_rw = rw; bus_byte = byt;
      it.due  = cyc + 1;
      it.e    = model(a, d, rw, byt, vld, 1'b1);
      it.e_nd = model(a, d, rw, byt, vld, 1'b0);
      it.req  = req;
      q.push_back(it);
   endtask

   // R2: register write, bus idle; model follows the register map
   task automatic wr(input logic [2:0] sel, input logic [7:0] val);
      drive(1'b1, sel, val, 1'b0, 24'h0, 16'h0, 1'b0, 1'b0, 2);
      case (sel)
         3'd0: m_addr[7:0]   = val;
         3'd1: m_addr[15:8]  = val;
         3'd2: m_addr[23:16] = val;
         3'd3: m_data[7:0]   = val;
         3'd4: m_data[15:8]  = val;
         3'd5: m_mask[7:0]   = val;
         3'd6: m_mask[15:8]  = val;
         default: m_ctrl     = val[5:0];
      endcase
   endtask

   task automatic bus(input logic vld, input logic [23:0] a, input logic [15:0] d,
                      input logic rw, input logic byt, input int req);
      drive(1'b0, 3'd0, 8'h0, vld, a, d, rw, byt, req);
   endtask

   // monitor: pops expectations as results become due
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due == cyc) begin
         item_t it;
         it = q.pop_front();
         total++;
         if (match !== it.e) begin
            bad++;
            $display("FAIL R%0d match actual=%b expected=%b (cycle %0d)", it.req, match, it.e, cyc);
         end
         total++;
         if (match_nd !== it.e_nd) begin
            bad++;
            $display("FAIL R%0d addr-only match actual=%b expected=%b (cycle %0d)",
                     it.req, match_nd, it.e_nd, cyc);
         end
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R11 watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: quiet after reset, registers zero so address 0 hits once enabled
      bus(1'b1, 24'h000000, 16'h0, 1'b0, 1'b0, 1);
      wr(3'd7, 8'h01);
      bus(1'b1, 24'h000000, 16'h1234, 1'b1, 1'b0, 1);
      bus(1'b1, 24'h000001, 16'h0, 1'b0, 1'b0, 1);

      // R2, R3: program address, probe near misses
      wr(3'd0, 8'h56); wr(3'd1, 8'h34); wr(3'd2, 8'h12);
      bus(1'b1, 24'h123456, 16'h0, 1'b0, 1'b0, 3);
      bus(1'b1, 24'h123457, 16'h0, 1'b0, 1'b0, 3);
      bus(1'b1, 24'h923456, 16'h0, 1'b0, 1'b0, 3);
      bus(1'b1, 24'h123c56, 16'h0, 1'b0, 1'b0, 3);
      // R4: matching address without valid
      bus(1'b0, 24'h123456, 16'h0, 1'b0, 1'b0, 4);
      // R11: back-to-back hits, then a gap
      bus(1'b1, 24'h123456, 16'h0, 1'b1, 1'b0, 11);
      bus(1'b1, 24'h123456, 16'h0, 1'b0, 1'b1, 11);
      bus(1'b0, 24'h123456, 16'h0, 1'b0, 1'b0, 11);
      // R5: disabled comparator
      wr(3'd7, 8'h00);
      bus(1'b1, 24'h123456, 16'h0, 1'b0, 1'b0, 5);
      wr(3'd7, 8'h3E);
      bus(1'b1, 24'h123456, 16'h0, 1'b1, 1'b1, 5);

      // R6, R10: masked data compare, mask 0xFF0F ignores bits 7:4
      wr(3'd3, 8'hC3); wr(3'd4, 8'hA5); wr(3'd5, 8'h0F); wr(3'd6, 8'hFF);
      wr(3'd7, 8'h03);
      bus(1'b1, 24'h123456, 16'hA5C3, 1'b0, 1'b0, 6);
      bus(1'b1, 24'h123456, 16'hA5F3, 1'b0, 1'b0, 6);
      bus(1'b1, 24'h123456, 16'hA4C3, 1'b0, 1'b0, 6);
      bus(1'b1, 24'h123456, 16'hA5C2, 1'b0, 1'b0, 10);

      // R7: direction qualifier
      wr(3'd7, 8'h0D);
      bus(1'b1, 24'h123456, 16'h0, 1'b1, 1'b0, 7);
      bus(1'b1, 24'h123456, 16'h0, 1'b0, 1'b0, 7);
      wr(3'd7, 8'h05);
      bus(1'b1, 24'h123456, 16'h0, 1'b0, 1'b0, 7);
      bus(1'b1, 24'h123456, 16'h0, 1'b1, 1'b0, 7);

      // R8: size qualifier
      wr(3'd7, 8'h11);
      bus(1'b1, 24'h123456, 16'h0, 1'b0, 1'b0, 8);
      bus(1'b1, 24'h123456, 16'h0, 1'b0, 1'b1, 8);
      wr(3'd7, 8'h31);
      bus(1'b1, 24'h123456, 16'h0, 1'b0, 1'b1, 8);
      bus(1'b1, 24'h123456, 16'h0, 1'b0, 1'b0, 8);

      // R9: byte lanes, full mask
      wr(3'd5, 8'hFF);
      wr(3'd7, 8'h33);
      bus(1'b1, 24'h123456, 16'hA500, 1'b0, 1'b1, 9);
      bus(1'b1, 24'h123456, 16'h00C3, 1'b0, 1'b1, 9);
      wr(3'd0, 8'h57);
      bus(1'b1, 24'h123457, 16'h11C3, 1'b0, 1'b1, 9);
      bus(1'b1, 24'h123457, 16'hA511, 1'b0, 1'b1, 9);

      bus(1'b0, 24'h0, 16'h0, 1'b0, 1'b0, 4);
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule